// File: doc/BRIEF.md
# Prefetch Request Filter Buffer

This block sits between a hardware prefetch predictor and the tag array of a first-level data cache. Before any tag lookup is made, it compares each candidate prefetch address with a small, fully associative list of the cache lines that were prefetched most recently. On a match it drops the request, on the assumption that the line is still resident. On a miss it forwards the request to the normal tag lookup and records the line. The aim is to cut the number of associative tag checks that prefetches cause, because most of them would find the line already present.

The list is kept in true least-recently-used order, as a shift stack whose slot 0 holds the most recent line. A missing line is pushed in at the front, and the oldest entry falls off the end once the list is full. A hit moves its entry to the front. The list is never told when the cache evicts a line. A stale entry can therefore drop a prefetch that would have been useful, and this is accepted. A flush input empties the list. Lookup and the drop/forward decision are combinational in the request cycle. The list is updated at the following clock edge.

Top module: `pf_filter_buf`

## Requirements
- R1: After reset the list is empty. The first request for any line is forwarded and is not dropped.
- R2: Comparison uses only the line tag, meaning the address bits above the low log2(LINE_BYTES) offset bits (bits 4:0 with the default 32-byte lines). Two addresses in the same line match, and addresses in adjacent lines do not.
- R3: A request whose line tag matches a valid entry raises drop_o and hit_stb_o in the same cycle. It leaves fwd_vld_o and miss_stb_o low.
- R4: A request that matches no entry raises fwd_vld_o and miss_stb_o in the same cycle, with fwd_addr_o equal to req_addr_i. It leaves drop_o and hit_stb_o low.
- R5: The line of a forwarded request (without flush) is recorded at the next clock edge. A later request to that line is dropped for as long as the entry remains.
- R6: When all DEPTH entries are valid and a new line is recorded, the least recently used entry is discarded. A later request to the discarded line is forwarded.
- R7: A hit makes its entry the most recently used. With a full list, a line that was hit after its insertion outlives lines that were inserted after it but not hit since.
- R8: A flush cycle invalidates every entry, so a request in any later cycle to a previously recorded line is forwarded.
- R9: A request presented while flush_i is high is always forwarded and is not recorded.
- R10: With req_vld_i low, fwd_vld_o, drop_o and both strobes stay low, and the address on req_addr_i is not recorded.
- R11: DEPTH may be set from 1 to 16. No two valid entries ever hold the same line tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flush_i | input | 1 | Invalidate all entries at the clock edge |
| req_vld_i | input | 1 | Candidate prefetch request valid |
| req_addr_i | input | ADDR_W | Candidate prefetch byte address |
| fwd_vld_o | output | 1 | Request passed on to the L1 tag lookup |
| fwd_addr_o | output | ADDR_W | Address of the passed-on request |
| drop_o | output | 1 | Request discarded by the filter |
| hit_stb_o | output | 1 | One-cycle strobe per filtered hit |
| miss_stb_o | output | 1 | One-cycle strobe per filter miss |

## Verification
The filter is tried with repeated requests to one line at different offsets, which separates tag-only matching from full-address matching. It is also tried with a straight fill of distinct lines one past the depth, which shows whether the oldest entry is the one evicted. A fill followed by a hit on the oldest line and one more insert separates true LRU order from plain insertion order. Idle cycles with a changing address, and requests made during a flush, show whether state changes only on forwarded, non-flush requests.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

  // Width of an index into a list of n slots (at least 1 bit)
  function automatic int unsigned ptr_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Per-cycle operation applied to the recency stack
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_HIT   = 2'd1,
    OP_MISS  = 2'd2,
    OP_FLUSH = 2'd3
  } pfb_op_e;

endpackage

// File: rtl/pfb_rst_sync.sv
module pfb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/pfb_match.sv
module pfb_match #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned TAG_W = 27,
  parameter int unsigned IDX_W = 3
) (
  input  logic [DEPTH-1:0][TAG_W-1:0] tags_i,
  input  logic [DEPTH-1:0]            vld_i,
  input  logic [TAG_W-1:0]            key_i,
  output logic [DEPTH-1:0]            match_o,
  output logic                        hit_o,
  output logic [IDX_W-1:0]            idx_o
);

  // One comparator per slot
  for (genvar s = 0; s < DEPTH; s++) begin : g_cmp
    assign match_o[s] = vld_i[s] && (tags_i[s] == key_i);
  end

  assign hit_o = |match_o;

  // Entries are unique, so an OR-encoder is enough
  always_comb begin
    idx_o = '0;
    for (int s = 0; s < DEPTH; s++) begin
      if (match_o[s]) begin
        idx_o = idx_o | IDX_W'(s);
      end
    end
  end

endmodule

// File: rtl/pfb_lru_stack.sv
module pfb_lru_stack
  import pfb_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned TAG_W = 27,
  parameter int unsigned IDX_W = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  pfb_op_e                     op_i,
  input  logic [TAG_W-1:0]            key_i,
  input  logic [IDX_W-1:0]            hit_idx_i,
  output logic [DEPTH-1:0][TAG_W-1:0] tags_o,
  output logic [DEPTH-1:0]            vld_o
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [DEPTH-1:0][TAG_W-1:0] tag_q, tag_d;
  logic [DEPTH-1:0]            vld_q, vld_d;
  logic                        shift_en;
  logic                        clear;
  logic [IDX_W-1:0]            limit;

  assign shift_en = (op_i == OP_HIT) || (op_i == OP_MISS);
  assign clear    = (op_i == OP_FLUSH);
  // A hit at slot k moves slots 0..k-1 down by one, a miss moves them all
  assign limit    = (op_i == OP_HIT) ? hit_idx_i : LAST;

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    if (s == 0) begin : g_head
      always_comb begin
        tag_d[s] = shift_en ? key_i : tag_q[s];
        vld_d[s] = clear ? 1'b0 : (shift_en ? 1'b1 : vld_q[s]);
      end
    end else begin : g_body
      localparam logic [IDX_W-1:0] SLOT = IDX_W'(s);
      logic move;
      assign move = shift_en && (SLOT <= limit);
      always_comb begin
        tag_d[s] = move ? tag_q[s-1] : tag_q[s];
        vld_d[s] = clear ? 1'b0 : (move ? vld_q[s-1] : vld_q[s]);
      end
    end
  end

  // Tag storage: no reset, written only when the stack shifts
  always_ff @(posedge clk) begin
    if (shift_en) begin
      tag_q <= tag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      vld_q <= vld_d;
    end
  end

  assign tags_o = tag_q;
  assign vld_o  = vld_q;

endmodule

// File: rtl/pf_filter_buf.sv
module pf_filter_buf
  import pfb_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 32,
  parameter int unsigned DEPTH      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              req_vld_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              fwd_vld_o,
  output logic [ADDR_W-1:0] fwd_addr_o,
  output logic              drop_o,
  output logic              hit_stb_o,
  output logic              miss_stb_o
);

  localparam int unsigned OFS_W = $clog2(LINE_BYTES);
  localparam int unsigned TAG_W = ADDR_W - OFS_W;
  localparam int unsigned IDX_W = ptr_bits(DEPTH);

  logic                        rst_q_n;
  logic [TAG_W-1:0]            line_tag;
  logic [DEPTH-1:0][TAG_W-1:0] tags;
  logic [DEPTH-1:0]            vlds;
  logic [DEPTH-1:0]            match_vec;
  logic                        hit;
  logic [IDX_W-1:0]            hit_idx;
  pfb_op_e                     op;

  pfb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_q_n)
  );

  assign line_tag = req_addr_i[ADDR_W-1:OFS_W];

  pfb_match #(
    .DEPTH (DEPTH),
    .TAG_W (TAG_W),
    .IDX_W (IDX_W)
  ) u_match (
    .tags_i  (tags),
    .vld_i   (vlds),
    .key_i   (line_tag),
    .match_o (match_vec),
    .hit_o   (hit),
    .idx_o   (hit_idx)
  );

  // Decide the stack operation for this cycle
  always_comb begin
    if (flush_i) begin
      op = OP_FLUSH;
    end else if (!req_vld_i) begin
      op = OP_IDLE;
    end else if (hit) begin
      op = OP_HIT;
    end else begin
      op = OP_MISS;
    end
  end

  pfb_lru_stack #(
    .DEPTH (DEPTH),
    .TAG_W (TAG_W),
    .IDX_W (IDX_W)
  ) u_stack (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .op_i      (op),
    .key_i     (line_tag),
    .hit_idx_i (hit_idx),
    .tags_o    (tags),
    .vld_o     (vlds)
  );

  // A flush in the same cycle makes the list count as empty
  assign drop_o     = req_vld_i && !flush_i && hit;
  assign fwd_vld_o  = req_vld_i && (flush_i || !hit);
  assign fwd_addr_o = req_addr_i;
  assign hit_stb_o  = drop_o;
  assign miss_stb_o = fwd_vld_o;

endmodule

// File: rtl/pfb_checker.sv
module pfb_checker #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 32,
  parameter int unsigned DEPTH      = 8
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              flush_i,
  input logic              req_vld_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              fwd_vld_o,
  input logic [ADDR_W-1:0] fwd_addr_o,
  input logic              drop_o,
  input logic [DEPTH-1:0]  match_vec
);

  localparam int unsigned OFS_W = $clog2(LINE_BYTES);

  // R3: a dropped request is never also forwarded
  a_r3_drop_excl: assert property (@(posedge clk) disable iff (!rst_q_n)
    drop_o |-> !fwd_vld_o);

  // R4: forwarded address is the request address
  a_r4_fwd_addr: assert property (@(posedge clk) disable iff (!rst_q_n)
    fwd_vld_o |-> (fwd_addr_o == req_addr_i));

  // R10: nothing comes out without a request
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_q_n)
    !req_vld_i |-> (!fwd_vld_o && !drop_o));

  // R5: back-to-back requests to one line: the second is dropped
  a_r5_recorded: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_vld_i && !flush_i) |=>
      (!(req_vld_i && !flush_i &&
         req_addr_i[ADDR_W-1:OFS_W] == $past(req_addr_i[ADDR_W-1:OFS_W]))
       || drop_o));

  // R8: after a flush cycle every request misses
  a_r8_flush_empty: assert property (@(posedge clk) disable iff (!rst_q_n)
    flush_i |=> (!req_vld_i || fwd_vld_o));

  // R9: a request during flush is forwarded
  a_r9_flush_fwd: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_vld_i && flush_i) |-> fwd_vld_o);

  // R11: entries stay unique, so at most one comparator fires
  a_r11_unique: assert property (@(posedge clk) disable iff (!rst_q_n)
    $onehot0(match_vec));

endmodule

bind pf_filter_buf pfb_checker #(
  .ADDR_W     (ADDR_W),
  .LINE_BYTES (LINE_BYTES),
  .DEPTH      (DEPTH)
) u_pfb_chk (
  .clk        (clk),
  .rst_q_n    (rst_q_n),
  .flush_i    (flush_i),
  .req_vld_i  (req_vld_i),
  .req_addr_i (req_addr_i),
  .fwd_vld_o  (fwd_vld_o),
  .fwd_addr_o (fwd_addr_o),
  .drop_o     (drop_o),
  .match_vec  (match_vec)
);

// File: tb/tb_pf_filter_buf.sv
`timescale 1ns/1ps
module tb_pf_filter_buf;

  localparam int unsigned ADDR_W = 32;
  localparam int unsigned LINE   = 32;
  localparam int unsigned DEPTH  = 8;
  localparam logic [31:0] BASE   = 32'h1000_0000;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              flush_i;
  logic              req_vld_i;
  logic [ADDR_W-1:0] req_addr_i;
  logic              fwd_vld_o;
  logic [ADDR_W-1:0] fwd_addr_o;
  logic              drop_o;
  logic              hit_stb_o;
  logic              miss_stb_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  pf_filter_buf #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE),
    .DEPTH      (DEPTH)
  ) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush_i    (flush_i),
    .req_vld_i  (req_vld_i),
    .req_addr_i (req_addr_i),
    .fwd_vld_o  (fwd_vld_o),
    .fwd_addr_o (fwd_addr_o),
    .drop_o     (drop_o),
    .hit_stb_o  (hit_stb_o),
    .miss_stb_o (miss_stb_o)
  );

  function automatic logic [31:0] ln(input int n, input int ofs);
    return BASE + 32'(n * LINE) + 32'(ofs);
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp,
                       input string rq, input string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // One request cycle, checked at mid-cycle; state updates at the next edge
  task automatic req(input logic [31:0] a, input logic fl,
                     input logic exp_drop, input string rq);
    @(negedge clk);
    req_vld_i  = 1'b1;
    req_addr_i = a;
    flush_i    = fl;
    #1;
    check(32'(drop_o),     32'(exp_drop),  rq, "drop");
    check(32'(fwd_vld_o),  32'(!exp_drop), rq, "fwd_vld");
    check(32'(hit_stb_o),  32'(exp_drop),  rq, "hit_stb");
    check(32'(miss_stb_o), 32'(!exp_drop), rq, "miss_stb");
    if (!exp_drop) check(fwd_addr_o, a, rq, "fwd_addr");
    @(posedge clk);
    #1;
    req_vld_i = 1'b0;
    flush_i   = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush_i   = 1'b1;
    req_vld_i = 1'b0;
    @(posedge clk);
    #1;
    flush_i = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(32'(fwd_vld_o | drop_o | hit_stb_o | miss_stb_o), 0, "R1", "idle outputs");
    req(ln(1, 0), 1'b0, 1'b0, "R1");
    req(ln(2, 4), 1'b0, 1'b0, "R4");
  endtask

  task automatic t_offset();
    req(ln(1, 31), 1'b0, 1'b1, "R2");
    req(ln(1, 8),  1'b0, 1'b1, "R3");
    req(ln(3, 0),  1'b0, 1'b0, "R2");
    req(ln(3, 17), 1'b0, 1'b1, "R5");
  endtask

  task automatic t_idle();
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      req_vld_i  = 1'b0;
      req_addr_i = ln(9, k);
      #1;
      check(32'(fwd_vld_o | drop_o | hit_stb_o | miss_stb_o), 0, "R10", "idle outputs");
    end
    req(ln(9, 0), 1'b0, 1'b0, "R10");
  endtask

  task automatic t_lru_evict();
    do_flush();
    req(ln(1, 0), 1'b0, 1'b0, "R8");
    do_flush();
    for (int k = 0; k < DEPTH; k++) req(ln(20 + k, 0), 1'b0, 1'b0, "R6");
    req(ln(28, 0), 1'b0, 1'b0, "R6");   // evicts line 20
    req(ln(20, 0), 1'b0, 1'b0, "R6");   // evicts line 21
    req(ln(21, 0), 1'b0, 1'b0, "R6");   // evicts line 22
    req(ln(23, 0), 1'b0, 1'b1, "R6");
  endtask

  task automatic t_refresh();
    do_flush();
    for (int k = 0; k < DEPTH; k++) req(ln(30 + k, 0), 1'b0, 1'b0, "R7");
    req(ln(30, 0), 1'b0, 1'b1, "R7");   // line 30 now most recent
    req(ln(38, 0), 1'b0, 1'b0, "R7");   // evicts line 31
    req(ln(30, 0), 1'b0, 1'b1, "R7");
    req(ln(31, 0), 1'b0, 1'b0, "R7");
  endtask

  task automatic t_flush_req();
    req(ln(40, 0), 1'b0, 1'b0, "R9");
    req(ln(40, 0), 1'b1, 1'b0, "R9");   // forwarded although recorded
    req(ln(41, 0), 1'b1, 1'b0, "R9");
    req(ln(41, 0), 1'b0, 1'b0, "R9");   // not recorded during flush
    req(ln(40, 0), 1'b0, 1'b0, "R8");
    req(ln(41, 0), 1'b0, 1'b1, "R11");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n      = 1'b0;
    flush_i    = 1'b0;
    req_vld_i  = 1'b0;
    req_addr_i = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_offset();
    t_idle();
    t_lru_evict();
    t_refresh();
    t_flush_req();
    repeat (2) @(posedge clk);
    finish_run();
  end

endmodule